// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO bank

This block is one bank of general-purpose pins. Each pin is set up through four per-pin control vectors to do one of three jobs. It can hand the pad over to an on-chip peripheral and name that peripheral with a 2-bit function number. It can act as a plain software-controlled input or output. It can act as an interrupt source with a selectable edge or level trigger. Software reaches the control vectors through a small word-addressed window. Every control vector has three write views: load, set-ones and clear-ones. A single pin can therefore be changed without reading the vector first.

Pin inputs pass through a two-stage synchronizer. The synchronized levels can be read back and also feed the trigger logic. A trigger latches a sticky per-pin flag. The bank drives one interrupt line, which is high while any flag on a pin in interrupt mode is unmasked. Only one edge or one level can be watched per pin. Software that needs both edges rewrites the polarity each time it acknowledges a flag.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset the mask and pattern-high vectors (offsets 0x20, 0x30) read all ones. The interrupt-select, pattern-low and flag vectors (0x10, 0x40, 0x50) read zero. No pin is driven, no pin is in peripheral mode and the interrupt line is low.
- R2: For each control vector at base offset B (0x10 select, 0x20 mask, 0x30 pattern-high, 0x40 pattern-low), a write to B loads the whole vector. A write to B+4 sets the bits written as 1. A write to B+8 clears the bits written as 1. Zero bits leave the vector unchanged. Reads at B, B+4 or B+8 return the vector. Accesses at B+0xC and non-word-aligned addresses are ignored, and reads there return zero.
- R3: Offset 0x00 reads the synchronized pin levels. A change on pin_in shows there two clock edges later. Writes to 0x00 have no effect.
- R4: A pin with select=0, mask=1 and pattern-high=0 is an output: pin_oe is 1 and pin_out equals its pattern-low bit. With pattern-high=1 it is an input: pin_oe is 0. pin_out is 0 on any pin that is not driven.
- R5: A pin with select=0 and mask=0 is in peripheral mode. func_en is 1 and func_sel[2i+1:2i] = {pattern-high, pattern-low}. pin_oe is 0. Outside this mode func_en and the function number are 0.
- R6: With select=1, the pair {pattern-high, pattern-low} sets the trigger: 11 rising edge, 10 falling edge, 01 high level, 00 low level. An edge on pin_in sets the pin's flag on the third clock edge after the change.
- R7: A level-triggered flag is set on every cycle that the active level is present, so a clear has no lasting effect while the level holds.
- R8: A flag is cleared only by writing 1 to its bit at offset 0x58. Zero bits there, and writes to 0x50 or 0x54, leave the flags unchanged.
- R9: irq_out is high exactly while some pin has flag=1, mask=0 and select=1. A masked or deselected flag stays latched and readable at 0x50.
- R10: Each pin watches only its one selected edge. A pin set for rising edges ignores falling edges. After the polarity is flipped, the opposite edge is caught.
- R11: A pin whose select bit is 0 never sets its flag, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset within the bank window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Raw pad input levels |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables |
| func_en | output | 32 | Pin handed to a peripheral |
| func_sel | output | 64 | 2-bit peripheral function number per pin |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The bench goes after the alias writes. A design that decoded the set and clear views the wrong way round, or wrote whole words there, would corrupt neighbouring pins. It also checks the reserved +0xC view and the read-only level and flag words: a loose decode would let those accesses change state. It emulates both-edge detection by acknowledging and flipping the polarity. This catches a detector that fires on both edges, misses the new edge or raises a spurious flag when the polarity changes. It holds a level trigger across a clear, which shows whether set wins over clear. It masks and deselects a latched flag, which tells apart a design that gates the interrupt line from one that wrongly drops the flag itself.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [3:0] {
        REG_LEVEL = 4'h0,
        REG_ISEL  = 4'h1,
        REG_MASK  = 4'h2,
        REG_PATH  = 4'h3,
        REG_PATL  = 4'h4,
        REG_FLAG  = 4'h5
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACC_BASE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_RSVD = 2'd3
    } acc_e;

    // {pattern-high, pattern-low} while the pin is an interrupt source
    typedef enum logic [1:0] {
        TRIG_LVL_LO = 2'b00,
        TRIG_LVL_HI = 2'b01,
        TRIG_FALL   = 2'b10,
        TRIG_RISE   = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        PMODE_FUNC,
        PMODE_GIN,
        PMODE_GOUT,
        PMODE_IRQ
    } pmode_e;

    typedef struct packed {
        logic       ok;
        logic [3:0] sel;
        acc_e       acc;
    } dec_t;

    function automatic dec_t decode_addr(logic [ADDR_W-1:0] a);
        dec_t d;
        d.sel = a[7:4];
        d.acc = acc_e'(a[3:2]);
        d.ok  = (a[1:0] == 2'b00) && (d.acc != ACC_RSVD);
        return d;
    endfunction

    function automatic pmode_e pin_mode(logic isel, logic msk, logic path);
        if (isel)       return PMODE_IRQ;
        else if (!msk)  return PMODE_FUNC;
        else if (path)  return PMODE_GIN;
        else            return PMODE_GOUT;
    endfunction

    function automatic logic trig_hit(trig_e t, logic now, logic prev);
        case (t)
            TRIG_RISE:   return now & ~prev;
            TRIG_FALL:   return ~now & prev;
            TRIG_LVL_HI: return now;
            default:     return ~now;
        endcase
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
`timescale 1ns/1ps
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_PINS-1:0] wdata,
    input  logic [N_PINS-1:0] level,
    input  logic [N_PINS-1:0] flag,
    output logic [N_PINS-1:0] rdata,
    output logic [N_PINS-1:0] isel_q,
    output logic [N_PINS-1:0] mask_q,
    output logic [N_PINS-1:0] path_q,
    output logic [N_PINS-1:0] patl_q,
    output logic [N_PINS-1:0] flag_clr
);

    localparam int N_CTL = 4;

    dec_t dec;
    assign dec = decode_addr(addr);

    // control vectors 0..3 sit at select codes 1..4
    for (genvar r = 0; r < N_CTL; r++) begin : g_ctl
        localparam logic [3:0] SEL    = 4'(r + 1);
        localparam logic       RST_HI = (r == 1) || (r == 2);
        logic [N_PINS-1:0] q;
        logic              hit;
        assign hit = wr_en && dec.ok && (dec.sel == SEL);
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= {N_PINS{RST_HI}};
            end else if (hit) begin
                case (dec.acc)
                    ACC_BASE: q <= wdata;
                    ACC_SET:  q <= q | wdata;
                    ACC_CLR:  q <= q & ~wdata;
                    default:  q <= q;
                endcase
            end
        end
    end

    assign isel_q = g_ctl[0].q;
    assign mask_q = g_ctl[1].q;
    assign path_q = g_ctl[2].q;
    assign patl_q = g_ctl[3].q;

    assign flag_clr = (wr_en && dec.ok && dec.sel == REG_FLAG && dec.acc == ACC_CLR)
                      ? wdata : '0;

    always_comb begin
        rdata = '0;
        if (dec.ok) begin
            case (dec.sel)
                REG_LEVEL: rdata = level;
                REG_ISEL:  rdata = isel_q;
                REG_MASK:  rdata = mask_q;
                REG_PATH:  rdata = path_q;
                REG_PATL:  rdata = patl_q;
                REG_FLAG:  rdata = flag;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
module gpio_trig_detect
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [N_PINS-1:0] isel,
    input  logic [N_PINS-1:0] path,
    input  logic [N_PINS-1:0] patl,
    input  logic [N_PINS-1:0] flag_clr,
    output logic [N_PINS-1:0] level,
    output logic [N_PINS-1:0] flag_q
);

    logic [N_PINS-1:0] meta_q, sync_q, prev_q, hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        trig_e kind;
        assign kind   = trig_e'({path[i], patl[i]});
        assign hit[i] = isel[i] & trig_hit(kind, sync_q[i], prev_q[i]);
    end

    // a new trigger wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~flag_clr) | hit;
    end

    assign level = sync_q;

endmodule

// File: rtl/gpio_pin_drive.sv
`timescale 1ns/1ps
module gpio_pin_drive
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic [N_PINS-1:0]   isel,
    input  logic [N_PINS-1:0]   mask,
    input  logic [N_PINS-1:0]   path,
    input  logic [N_PINS-1:0]   patl,
    output logic [N_PINS-1:0]   pin_out,
    output logic [N_PINS-1:0]   pin_oe,
    output logic [N_PINS-1:0]   func_en,
    output logic [2*N_PINS-1:0] func_sel
);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        pmode_e mode;
        assign mode            = pin_mode(isel[i], mask[i], path[i]);
        assign pin_oe[i]       = (mode == PMODE_GOUT);
        assign pin_out[i]      = (mode == PMODE_GOUT) & patl[i];
        assign func_en[i]      = (mode == PMODE_FUNC);
        assign func_sel[2*i+:2] = (mode == PMODE_FUNC) ? {path[i], patl[i]} : 2'b00;
    end

endmodule

// File: rtl/gpio_bank_irq.sv
`timescale 1ns/1ps
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [N_PINS-1:0]   bus_wdata,
    output logic [N_PINS-1:0]   bus_rdata,
    input  logic [N_PINS-1:0]   pin_in,
    output logic [N_PINS-1:0]   pin_out,
    output logic [N_PINS-1:0]   pin_oe,
    output logic [N_PINS-1:0]   func_en,
    output logic [2*N_PINS-1:0] func_sel,
    output logic                irq_out
);

    logic [N_PINS-1:0] isel_q, mask_q, path_q, patl_q;
    logic [N_PINS-1:0] flag_clr, flag_q, level;

    gpio_regfile #(.N_PINS(N_PINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .level    (level),
        .flag     (flag_q),
        .rdata    (bus_rdata),
        .isel_q   (isel_q),
        .mask_q   (mask_q),
        .path_q   (path_q),
        .patl_q   (patl_q),
        .flag_clr (flag_clr)
    );

    gpio_trig_detect #(.N_PINS(N_PINS)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .isel     (isel_q),
        .path     (path_q),
        .patl     (patl_q),
        .flag_clr (flag_clr),
        .level    (level),
        .flag_q   (flag_q)
    );

    gpio_pin_drive #(.N_PINS(N_PINS)) u_drive (
        .isel     (isel_q),
        .mask     (mask_q),
        .path     (path_q),
        .patl     (patl_q),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .func_en  (func_en),
        .func_sel (func_sel)
    );

    assign irq_out = |(flag_q & ~mask_q & isel_q);

endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk #(
    parameter int N_PINS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [N_PINS-1:0] pin_in,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe,
    input logic              irq_out,
    input logic [N_PINS-1:0] level,
    input logic [N_PINS-1:0] patl,
    input logic [N_PINS-1:0] isel,
    input logic [N_PINS-1:0] flag
);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R3: read-back level lags the pad input by two edges
    p_sync_lag_r3: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (level == $past(pin_in, 2)));

    // R4: a driven pin carries its pattern-low bit, an undriven pin drives 0
    p_drive_value_r4: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & (pin_out ^ patl)) == '0) && ((pin_out & ~pin_oe) == '0));

    // R8: without a bus write no latched flag ever drops
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr) |-> ((flag & $past(flag)) == $past(flag)));

    // R9: the interrupt line only drops as a result of a bus write
    p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_out) |-> $past(bus_wr));

    // R11: new flags only appear on pins that were interrupt sources
    p_flag_source_r11: assert property (@(posedge clk) disable iff (rst)
        ((flag & ~$past(flag)) & ~$past(isel)) == '0);

endmodule

bind gpio_bank_irq gpio_bank_chk #(.N_PINS(N_PINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_wr  (bus_wr),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq_out (irq_out),
    .level   (level),
    .patl    (patl_q),
    .isel    (isel_q),
    .flag    (flag_q)
);

// File: tb/gpio_bank_irq_tb.sv
`timescale 1ns/1ps
module gpio_bank_irq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, func_en;
    logic [63:0] func_sel;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_bank_irq u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .func_en(func_en),
        .func_sel(func_sel), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [7:0]  wa;
        logic [31:0] wd;
        logic [7:0]  ra;
        logic [31:0] ex;
        logic [3:0]  tg;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{8'h40, 32'hA5A5_0F0F, 8'h40, 32'hA5A5_0F0F, 4'd2}, // R2 load
        '{8'h44, 32'h0000_F000, 8'h40, 32'hA5A5_FF0F, 4'd2}, // R2 set view
        '{8'h48, 32'hA000_000F, 8'h40, 32'h05A5_FF00, 4'd2}, // R2 clear view
        '{8'h10, 32'h0000_00FF, 8'h10, 32'h0000_00FF, 4'd2}, // R2
        '{8'h18, 32'h0000_000F, 8'h10, 32'h0000_00F0, 4'd2}, // R2
        '{8'h00, 32'hFFFF_FFFF, 8'h00, 32'h0000_0000, 4'd3}, // R3 level is read-only
        '{8'h20, 32'h0000_0000, 8'h20, 32'h0000_0000, 4'd2}, // R2
        '{8'h24, 32'hFFFF_FFFF, 8'h20, 32'hFFFF_FFFF, 4'd2}, // R2
        '{8'h38, 32'h0000_0001, 8'h30, 32'hFFFF_FFFE, 4'd2}, // R2
        '{8'h50, 32'hFFFF_FFFF, 8'h50, 32'h0000_0000, 4'd8}, // R8 flag load ignored
        '{8'h54, 32'hFFFF_FFFF, 8'h50, 32'h0000_0000, 4'd8}, // R8 flag set ignored
        '{8'h4C, 32'h1234_5678, 8'h40, 32'h05A5_FF00, 4'd2}, // R2 reserved view
        '{8'h14, 32'h0000_0000, 8'h44, 32'h05A5_FF00, 4'd2}  // R2 read at alias
    };

    function automatic string tagname(logic [3:0] c);
        case (c)
            4'd3:    return "R3";
            4'd8:    return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic setpin(int k, logic v);
        @(negedge clk);
        pin_in[k] = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // table of register accesses
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].wa, VEC[i].wd);
            rd(VEC[i].ra, got);
            check(tagname(VEC[i].tg), {32'h0, got}, {32'h0, VEC[i].ex});
        end

        do_reset();

        // R1 reset state
        rd(8'h20, got); check("R1 mask", got, 32'hFFFF_FFFF);
        rd(8'h30, got); check("R1 pattern-high", got, 32'hFFFF_FFFF);
        rd(8'h10, got); check("R1 select", got, 0);
        rd(8'h40, got); check("R1 pattern-low", got, 0);
        rd(8'h50, got); check("R1 flag", got, 0);
        check("R1 oe", pin_oe, 0);
        check("R1 func_en", func_en, 0);
        check("R1 irq", irq_out, 0);

        // R3 two-edge read-back
        @(negedge clk); pin_in = 32'h1234_5678;
        cyc(1); rd(8'h00, got); check("R3 after one edge", got, 0);
        cyc(1); rd(8'h00, got); check("R3 after two edges", got, 32'h1234_5678);
        @(negedge clk); pin_in = '0;
        cyc(3);

        // R4 GPIO output and input on pin 3
        wr(8'h38, 32'h8);
        wr(8'h44, 32'h8);
        check("R4 oe", pin_oe, 32'h8);
        check("R4 out high", pin_out, 32'h8);
        wr(8'h48, 32'h8);
        check("R4 out low", pin_out, 0);
        wr(8'h34, 32'h8);
        check("R4 input mode", pin_oe, 0);

        // R5 peripheral mode on pin 5
        wr(8'h28, 32'h20);
        check("R5 func_en", func_en, 32'h20);
        check("R5 func 2", func_sel[11:10], 2'b10);
        check("R5 not driven", pin_oe, 0);
        wr(8'h44, 32'h20);
        check("R5 func 3", func_sel[11:10], 2'b11);
        wr(8'h38, 32'h20);
        check("R5 func 1", func_sel[11:10], 2'b01);
        wr(8'h24, 32'h20);
        wr(8'h34, 32'h20);
        wr(8'h48, 32'h20);
        check("R5 leaves mode", {32'h0, func_en}, 64'h0);

        // R6 rising edge on pin 8
        wr(8'h44, 32'h100);
        wr(8'h28, 32'h100);
        wr(8'h14, 32'h100);
        rd(8'h50, got); check("R6 no flag before edge", got, 0);
        setpin(8, 1'b1);
        cyc(2); rd(8'h50, got); check("R6 rise, two edges", got, 0);
        cyc(1); rd(8'h50, got); check("R6 rise, three edges", got, 32'h100);
        check("R9 irq on", irq_out, 1);

        // R8 clear semantics
        wr(8'h58, ~32'h100);
        rd(8'h50, got); check("R8 zero bits keep flag", got, 32'h100);
        wr(8'h58, 32'h100);
        rd(8'h50, got); check("R8 cleared", got, 0);
        check("R9 irq off after clear", irq_out, 0);
        cyc(3); rd(8'h50, got); check("R6 held level no refire", got, 0);

        // R10 both-edge emulation by flipping polarity
        wr(8'h48, 32'h100);
        cyc(2); rd(8'h50, got); check("R10 flip causes no flag", got, 0);
        setpin(8, 1'b0);
        cyc(3); rd(8'h50, got); check("R10 falling caught", got, 32'h100);
        wr(8'h58, 32'h100);
        wr(8'h44, 32'h100);
        setpin(8, 1'b1);
        cyc(3); rd(8'h50, got); check("R10 rising caught", got, 32'h100);
        wr(8'h58, 32'h100);
        setpin(8, 1'b0);
        cyc(5); rd(8'h50, got); check("R10 rising ignores fall", got, 0);

        // R9 masking and deselect
        setpin(8, 1'b1);
        cyc(3); check("R9 irq raised", irq_out, 1);
        wr(8'h24, 32'h100);
        check("R9 masked irq", irq_out, 0);
        rd(8'h50, got); check("R9 masked flag kept", got, 32'h100);
        wr(8'h28, 32'h100);
        check("R9 unmasked irq", irq_out, 1);
        wr(8'h18, 32'h100);
        check("R9 deselected irq", irq_out, 0);
        rd(8'h50, got); check("R9 deselected flag kept", got, 32'h100);
        wr(8'h58, 32'h100);

        // R7 level high on pin 9
        wr(8'h38, 32'h200);
        wr(8'h44, 32'h200);
        wr(8'h28, 32'h200);
        setpin(9, 1'b1);
        cyc(3); rd(8'h50, got); check("R11 no flag while deselected", got, 0);
        wr(8'h14, 32'h200);
        cyc(1); rd(8'h50, got); check("R6 level high", got, 32'h200);
        wr(8'h58, 32'h200);
        rd(8'h50, got); check("R7 re-asserts after clear", got, 32'h200);
        setpin(9, 1'b0);
        cyc(3);
        wr(8'h58, 32'h200);
        rd(8'h50, got); check("R7 clear after level gone", got, 0);

        // level low on pin 10
        wr(8'h38, 32'h400);
        wr(8'h28, 32'h400);
        wr(8'h14, 32'h400);
        cyc(1); rd(8'h50, got); check("R6 level low", got, 32'h400);
        check("R9 irq from level low", irq_out, 1);
        setpin(10, 1'b1);
        cyc(3);
        wr(8'h58, 32'h400);
        rd(8'h50, got); check("R7 level low released", got, 0);

        // R11 input pin toggling never flags
        setpin(12, 1'b1);
        cyc(3);
        setpin(12, 1'b0);
        cyc(3);
        rd(8'h50, got); check("R11 input pin no flag", got, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule